// File: doc/BRIEF.md
# Peripheral Interrupt Level Router

This block takes a vector of up to 64 peripheral interrupt lines and turns it into one request per general-purpose core priority level, 7 through 13, for the core event controller. Each line has a 4-bit priority ID that selects its core level. ID n drives core level n+7. Every line whose enable bit is set and whose ID selects a level contributes to that level's request. Any number of lines may share one level, and their requests are ORed.

Software reaches the block through a simple word-addressed register port. The port holds the per-line enable words, the read-only words that show the raw line levels, the per-line wake-enable words and the packed ID registers. A separate wake output rises whenever a line whose wake bit is set is active. The enable bits have no effect on that output. The input lines are sampled once per clock. Level requests and the wake output are registered one clock after that sample.

Register map (word addresses): 0 and 1 hold the enables for lines 0–31 and 32–63. 2 and 3 hold the status for the same lines. 4 and 5 hold the wake enables. 6 and 7 are unused. 8–15 hold the ID registers. Each ID register k holds lines 8k..8k+7, and line 8k+i sits in bits 4i+3:4i.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the enable words (addresses 0, 1) and wake-enable words (addresses 4, 5) read zero, `core_req` and `wake_out` are low, and the IDs take their reset defaults: lines 0–15 ID 4, lines 16–31 ID 5, lines 32–47 ID 3, lines 48–63 ID 6.
- R2: A line contributes to a level request only while its enable bit is 1 (bit s of word 0 for s<32, bit s-32 of word 1 otherwise). With the enable bit at 0 the line never raises `core_req`.
- R3: Status words 2 and 3 read the sampled level of each line whether or not it is enabled. Writes to these addresses change nothing.
- R4: A line with ID n in 0..6 drives `core_req` bit n, which is core level n+7. IDs 7..15 drive no level.
- R5: `core_req` bit n is the OR of every enabled, active line whose ID is n. It stays high while at least one such line remains active.
- R6: `wake_out` is high when any active line has its wake-enable bit set (words 4, 5, same bit layout as the enables), regardless of the enable words.
- R7: ID register 8+k holds the ID of line 8k+i in bits 4i+3:4i. It reads back exactly what was last written.
- R8: A line change is seen in status at the first clock edge after it, and in `core_req` and `wake_out` at the second. `rdata` shows the register addressed with `rd_en` one clock later, and reads zero when no read was issued.
- R9: Addresses 6 and 7 read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Peripheral interrupt lines, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| core_req | output | 7 | Request per core level, bit n is level n+7 |
| wake_out | output | 1 | Wake request |

## Verification
The hardest case is one level fed by several lines at once, where one line's enable or ID changes while the others stay active. The ID registers have to be rewritten mid-run, so a single line is moved through IDs 0, 2, 6, 7 and 15, and the level vector is checked after each move. Shared-level OR is tested by dropping lines one at a time from a level that is still held up by the others. A table of enable, wake-enable and line patterns then covers enable gating against wake independence in the same cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int ID_W     = 4;
    localparam int LVL_BASE = 7;
    localparam int NUM_LVL  = 7;
    localparam int WORD_W   = 32;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      irq_in,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORD_W-1:0]       rdata,
    output logic [NUM_SRC-1:0]      stat_o,
    output logic [NUM_SRC-1:0]      ena_o,
    output logic [NUM_SRC-1:0]      wen_o,
    output logic [NUM_SRC*ID_W-1:0] ids_o
);
    localparam int NUM_WORDS = NUM_SRC / WORD_W;
    localparam int ID_REGS   = NUM_SRC * ID_W / WORD_W;
    localparam int ENA_BASE  = 0;
    localparam int STAT_BASE = NUM_WORDS;
    localparam int WEN_BASE  = 2 * NUM_WORDS;
    localparam int ID_BASE   = 4 * NUM_WORDS;

    typedef struct packed {
        logic [NUM_SRC-1:0]      ena;
        logic [NUM_SRC-1:0]      wen;
        logic [NUM_SRC-1:0]      stat;
        logic [NUM_SRC*ID_W-1:0] ids;
        logic [WORD_W-1:0]       rdata;
    } regs_t;

    regs_t s_d, s_q;

    function automatic logic [NUM_SRC*ID_W-1:0] reset_ids();
        logic [NUM_SRC*ID_W-1:0] v;
        v = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            case ((s / 16) % 4)
                0:       v[s*ID_W +: ID_W] = ID_W'(4);
                1:       v[s*ID_W +: ID_W] = ID_W'(5);
                2:       v[s*ID_W +: ID_W] = ID_W'(3);
                default: v[s*ID_W +: ID_W] = ID_W'(6);
            endcase
        end
        return v;
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.stat  = irq_in;
        s_d.rdata = '0;
        if (wr_en) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (addr == ADDR_W'(ENA_BASE + w)) s_d.ena[w*WORD_W +: WORD_W] = wdata;
                if (addr == ADDR_W'(WEN_BASE + w)) s_d.wen[w*WORD_W +: WORD_W] = wdata;
            end
            for (int r = 0; r < ID_REGS; r++) begin
                if (addr == ADDR_W'(ID_BASE + r)) s_d.ids[r*WORD_W +: WORD_W] = wdata;
            end
        end
        if (rd_en) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (addr == ADDR_W'(ENA_BASE + w))  s_d.rdata = s_q.ena[w*WORD_W +: WORD_W];
                if (addr == ADDR_W'(STAT_BASE + w)) s_d.rdata = s_q.stat[w*WORD_W +: WORD_W];
                if (addr == ADDR_W'(WEN_BASE + w))  s_d.rdata = s_q.wen[w*WORD_W +: WORD_W];
            end
            for (int r = 0; r < ID_REGS; r++) begin
                if (addr == ADDR_W'(ID_BASE + r)) s_d.rdata = s_q.ids[r*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.ids <= reset_ids();
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata  = s_q.rdata;
    assign stat_o = s_q.stat;
    assign ena_o  = s_q.ena;
    assign wen_o  = s_q.wen;
    assign ids_o  = s_q.ids;
endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0]      active,
    input  logic [NUM_SRC*ID_W-1:0] ids,
    output logic [NUM_LVL-1:0]      lvl_req
);
    for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (active[s] && ids[s*ID_W +: ID_W] == ID_W'(j)) hit = 1'b1;
            end
        end
        assign lvl_req[j] = hit;
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    irq_in,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rdata,
    output logic [NUM_LVL-1:0]    core_req,
    output logic                  wake_out
);
    typedef struct packed {
        logic [NUM_LVL-1:0] req;
        logic               wake;
    } out_t;

    out_t o_d, o_q;

    logic [NUM_SRC-1:0]      stat_w, ena_w, wen_w;
    logic [NUM_SRC*ID_W-1:0] ids_w;
    logic [NUM_LVL-1:0]      lvl_w;

    irq_route_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .stat_o(stat_w), .ena_o(ena_w), .wen_o(wen_w),
        .ids_o(ids_w)
    );

    irq_route_map #(.NUM_SRC(NUM_SRC)) u_map (
        .active(stat_w & ena_w), .ids(ids_w), .lvl_req(lvl_w)
    );

    always_comb begin
        o_d      = o_q;
        o_d.req  = lvl_w;
        o_d.wake = |(stat_w & wen_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign core_req = o_q.req;
    assign wake_out = o_q.wake;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [NUM_LVL-1:0] core_req,
    input logic               wake_out,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] ena,
    input logic [NUM_SRC-1:0] wen
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_status_sample_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        stat == $past(irq_in));

    p_req_needs_enabled_line_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (core_req != '0) |-> $past(|(stat & ena)));

    p_no_enable_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(ena == '0) |-> (core_req == '0));

    p_wake_follows_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        wake_out == $past(|(stat & wen)));
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .core_req(core_req),
    .wake_out(wake_out), .stat(stat_w), .ena(ena_w), .wen(wen_w)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  core_req;
    logic        wake_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_route_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .core_req(core_req),
        .wake_out(wake_out)
    );

    typedef struct packed {
        logic [63:0] ena;
        logic [63:0] wen;
        logic [63:0] lines;
        logic [6:0]  req;
        logic        wake;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0,                  7'b0000000, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h1,                  7'b0010000, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0004_0000_0010_0000, 7'b1100000, 1'b0},
        '{64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,                  7'b0000000, 1'b0},
        '{64'h0, 64'h0000_0100_0000_0000, 64'h0000_0100_0000_0000, 7'b0000000, 1'b1},
        '{64'h0000_0002_0000_0000, 64'h400, 64'h0000_0006_0000_0000, 7'b0001000, 1'b0},
        '{64'hFFFF_FFFF_0000_0000, 64'h0, 64'h0000_0000_FFFF_FFFF, 7'b0000000, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive(input logic [63:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 core_req", core_req, 0);
        chk("R1 wake", wake_out, 0);
        chk("R8 rdata idle", rdata, 0);
        rd(4'd0, d); chk("R1 enable lo", d, 0);
        rd(4'd1, d); chk("R1 enable hi", d, 0);
        rd(4'd5, d); chk("R1 wake enable hi", d, 0);
        rd(4'd8, d);  chk("R1 id reg 8", d, 32'h4444_4444);
        rd(4'd10, d); chk("R1 id reg 10", d, 32'h5555_5555);
        rd(4'd12, d); chk("R1 id reg 12", d, 32'h3333_3333);
        rd(4'd15, d); chk("R1 id reg 15", d, 32'h6666_6666);

        // table of patterns: R2 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            wr(4'd0, VEC[i].ena[31:0]);  wr(4'd1, VEC[i].ena[63:32]);
            wr(4'd4, VEC[i].wen[31:0]);  wr(4'd5, VEC[i].wen[63:32]);
            drive(VEC[i].lines);
            chk($sformatf("R2/R4/R5 vector %0d core_req", i), core_req, VEC[i].req);
            chk($sformatf("R6 vector %0d wake", i), wake_out, VEC[i].wake);
        end
        drive(64'h0);
        wr(4'd4, 32'h0); wr(4'd5, 32'h0);

        // R8 latency
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
        @(negedge clk); irq_in = 64'h1;
        @(negedge clk); chk("R8 req one edge after change", core_req, 7'b0000000);
        @(negedge clk); chk("R8 req two edges after change", core_req, 7'b0010000);
        drive(64'h0);

        // R3 status independent of enables, read-only
        wr(4'd0, 32'h0); wr(4'd1, 32'h0);
        drive(64'hA5A5_0000_0000_1234);
        rd(4'd2, d); chk("R3 status lo", d, 32'h0000_1234);
        rd(4'd3, d); chk("R3 status hi", d, 32'hA5A5_0000);
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d); chk("R3 status write ignored", d, 32'h0000_1234);
        chk("R2 disabled lines no req", core_req, 0);
        drive(64'h0);

        // R4 ID mapping of line 5 (bits 23:20 of reg 8)
        wr(4'd0, 32'h20);
        wr(4'd8, 32'h4404_4444); drive(64'h20); chk("R4 id 0 -> bit0", core_req, 7'b0000001);
        wr(4'd8, 32'h4424_4444); drive(64'h20); chk("R4 id 2 -> bit2", core_req, 7'b0000100);
        wr(4'd8, 32'h4464_4444); drive(64'h20); chk("R4 id 6 -> bit6", core_req, 7'b1000000);
        wr(4'd8, 32'h4474_4444); drive(64'h20); chk("R4 id 7 no level", core_req, 7'b0000000);
        wr(4'd8, 32'h44F4_4444); drive(64'h20); chk("R4 id 15 no level", core_req, 7'b0000000);
        rd(4'd8, d); chk("R7 id reg readback", d, 32'h44F4_4444);
        wr(4'd14, 32'h0123_4567);
        rd(4'd14, d); chk("R7 id reg 14 readback", d, 32'h0123_4567);
        rd(4'd15, d); chk("R7 neighbour reg untouched", d, 32'h6666_6666);
        wr(4'd8, 32'h4444_4444);
        drive(64'h0);

        // R5 shared level
        wr(4'd0, 32'h0001_0003);
        drive(64'h0001_0003); chk("R5 shared level plus other", core_req, 7'b0110000);
        drive(64'h0000_0002); chk("R5 one remaining line holds level", core_req, 7'b0010000);
        drive(64'h0);         chk("R5 level drops", core_req, 7'b0000000);

        // R9 unused addresses
        wr(4'd6, 32'hDEAD_BEEF);
        rd(4'd6, d); chk("R9 addr 6 reads zero", d, 0);
        wr(4'd7, 32'hCAFE_F00D);
        rd(4'd7, d); chk("R9 addr 7 reads zero", d, 0);
        rd(4'd0, d); chk("R9 enable word unchanged", d, 32'h0001_0003);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule